// File: doc/BRIEF.md
# RC5 Infrared Frame Decoder

This block turns the demodulated output of an infrared receiver into RC5 remote-control codes. The receiver pin is active-low and idles high. The pin is synchronised and timed against a microsecond tick. After the line has been quiet for long enough, the block treats the first edge as the mid-bit transition of the first start bit. It then reads each following Manchester bit a quarter of a bit period after that bit begins.

The bit period is not fixed. Each time a mid-bit transition arrives, the interval since the previous one becomes the new reference, so a remote whose clock drifts during a frame still decodes. If a mid-bit transition has not arrived by three quarters into a bit, the frame is treated as truncated. The block then raises an error strobe and reports nothing.

A completed frame yields a 7-bit command, a 5-bit address and the toggle bit. Command bit 6 is rebuilt as the inverse of the second start bit. A frame whose toggle equals the toggle of the last accepted frame is a held-key repeat, and it is dropped without a strobe.

Top module: `ir_frame_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, `cmd_o`, `addr_o` and `toggle_o` are zero, and both strobes are low.
- R2: A frame starts decoding only on an edge that follows at least 5/4 of the nominal bit period of continuous high line. This holds after reset, after a finished frame and after an aborted frame. A frame preceded by a shorter high time is ignored: no strobe, and the outputs do not change.
- R3: Thirteen samples are taken in this order: second start bit, toggle, address A4..A0, command C5..C0. The sampled line level is the bit value. `addr_o[4]` is A4, `cmd_o[5:0]` is C5..C0, and `toggle_o` is the toggle bit.
- R4: `cmd_o[6]` equals the inverse of the sampled second start bit.
- R5: Each bit is sampled 3/4 of the current reference period after the preceding mid-bit edge. The first reference is the nominal period. The interval between successive mid-bit edges, clamped to between 1/2 and 2 nominal periods, becomes the next reference. A frame whose bit period drifts by several percent per bit therefore still decodes.
- R6: If no mid-bit edge arrives within 5/4 of the reference period after the previous one, `frame_err_o` pulses for one cycle. No valid strobe is given, and the outputs are left unchanged.
- R7: The first complete frame after reset is always accepted. After that, a complete frame is accepted only if its toggle differs from `toggle_o`. Otherwise it raises no strobe and leaves the outputs unchanged.
- R8: `cmd_valid_o` is high for exactly one cycle per accepted frame. The outputs change only in that cycle and hold until the next accepted frame.
- R9: `cmd_valid_o` and `frame_err_o` are never high in the same cycle.
- R10: All timing is measured in microsecond ticks, each tick lasting `CLKS_PER_US` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_n_i | input | 1 | Demodulated receiver output, asynchronous, idle high |
| cmd_o | output | CMD_W (7) | Command C6..C0 of the last accepted frame |
| addr_o | output | ADDR_W (5) | Address A4..A0 of the last accepted frame |
| toggle_o | output | 1 | Toggle bit of the last accepted frame |
| cmd_valid_o | output | 1 | One-cycle strobe for a newly accepted frame |
| frame_err_o | output | 1 | One-cycle strobe for an abandoned, truncated frame |

## Verification
The bound checker covers several properties on every cycle:
- both strobes are single-cycle;
- the two strobes never coincide;
- the outputs stay frozen outside a valid strobe;
- every accepted frame after the first carries a toggle different from its predecessor.

Only the bench scenarios can show that the bits land in the correct fields and that command bit 6 is the inverted start bit. The same holds for re-timing: frames whose period grows or shrinks bit by bit still decode. The bench scenarios also show that truncation is detected, and that a frame with too short an idle lead-in is ignored.

// File: rtl/ird_pkg.sv
package ird_pkg;
    // Sampler phases
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_WAIT_SAMPLE = 2'd1,
        ST_WAIT_EDGE   = 2'd2
    } ird_state_e;
endpackage

// File: rtl/ird_sync.sv
module ird_sync #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic edge_o
);
    typedef struct packed {
        logic [1:0] meta;
        logic       prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = {sync_q.meta[0], async_i};
        sync_d.prev = sync_q.meta[1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '{meta: {2{IDLE_LEVEL}}, prev: IDLE_LEVEL};
        else         sync_q <= sync_d;
    end

    assign level_o = sync_q.meta[1];
    assign edge_o  = sync_q.meta[1] ^ sync_q.prev;
endmodule

// File: rtl/ird_tick.sv
module ird_tick #(
    parameter int DIV = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            logic unused_clk_rst;
            assign unused_clk_rst = clk_i ^ rst_ni;
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ird_sampler.sv
module ird_sampler
    import ird_pkg::*;
#(
    parameter int BIT_TICKS = 1778,
    parameter int NS        = 13
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          level_i,
    input  logic          edge_i,
    output logic          done_o,
    output logic          abort_o,
    output logic [NS-1:0] bits_o
);
    localparam int TW   = $clog2(3 * BIT_TICKS) + 1;
    localparam int CNTW = $clog2(NS + 1);
    localparam logic [TW-1:0]   PNOM  = TW'(BIT_TICKS);
    localparam logic [TW-1:0]   PMAX  = TW'(2 * BIT_TICKS);
    localparam logic [TW-1:0]   PMIN  = TW'(BIT_TICKS / 2);
    localparam logic [TW-1:0]   ARM_T = TW'(BIT_TICKS + BIT_TICKS / 4);
    localparam logic [TW-1:0]   TMAX  = '1;
    localparam logic [CNTW-1:0] LAST  = CNTW'(NS - 1);

    typedef struct packed {
        ird_state_e      state;
        logic [TW-1:0]   timer;
        logic [TW-1:0]   period;
        logic [CNTW-1:0] cnt;
        logic [NS-1:0]   sh;
        logic            done;
        logic            abort;
    } smp_t;

    smp_t smp_d, smp_q;
    logic [TW-1:0] timer_inc, quarter3, quarter5, measured;

    always_comb begin
        timer_inc = (tick_i && smp_q.timer != TMAX) ? smp_q.timer + 1'b1 : smp_q.timer;
        quarter3  = (smp_q.period >> 1) + (smp_q.period >> 2);
        quarter5  = smp_q.period + (smp_q.period >> 2);
        if (smp_q.timer > PMAX)      measured = PMAX;
        else if (smp_q.timer < PMIN) measured = PMIN;
        else                         measured = smp_q.timer;

        smp_d       = smp_q;
        smp_d.done  = 1'b0;
        smp_d.abort = 1'b0;

        unique case (smp_q.state)
            ST_IDLE: begin
                if (edge_i && smp_q.timer >= ARM_T) begin
                    smp_d.state  = ST_WAIT_SAMPLE;
                    smp_d.timer  = '0;
                    smp_d.period = PNOM;
                    smp_d.cnt    = '0;
                end else if (!level_i) begin
                    smp_d.timer = '0;
                end else begin
                    smp_d.timer = timer_inc;
                end
            end
            ST_WAIT_SAMPLE: begin
                smp_d.timer = timer_inc;
                if (smp_q.timer >= quarter3) begin
                    smp_d.sh = {smp_q.sh[NS-2:0], level_i};
                    if (smp_q.cnt == LAST) begin
                        smp_d.done  = 1'b1;
                        smp_d.state = ST_IDLE;
                        smp_d.timer = '0;
                    end else begin
                        smp_d.cnt   = smp_q.cnt + 1'b1;
                        smp_d.state = ST_WAIT_EDGE;
                    end
                end
            end
            ST_WAIT_EDGE: begin
                if (edge_i) begin
                    smp_d.period = measured;
                    smp_d.timer  = '0;
                    smp_d.state  = ST_WAIT_SAMPLE;
                end else if (smp_q.timer >= quarter5) begin
                    smp_d.abort = 1'b1;
                    smp_d.state = ST_IDLE;
                    smp_d.timer = '0;
                end else begin
                    smp_d.timer = timer_inc;
                end
            end
            default: smp_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            smp_q <= '{state: ST_IDLE, timer: '0, period: PNOM, cnt: '0,
                       sh: '0, done: 1'b0, abort: 1'b0};
        end else begin
            smp_q <= smp_d;
        end
    end

    assign done_o  = smp_q.done;
    assign abort_o = smp_q.abort;
    assign bits_o  = smp_q.sh;
endmodule

// File: rtl/ird_repeat_filter.sv
module ird_repeat_filter #(
    parameter int AW = 5,
    parameter int CW = 7,
    parameter int NS = AW + CW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          done_i,
    input  logic          abort_i,
    input  logic [NS-1:0] bits_i,
    output logic [CW-1:0] cmd_o,
    output logic [AW-1:0] addr_o,
    output logic          tog_o,
    output logic          valid_o,
    output logic          err_o
);
    typedef struct packed {
        logic [CW-1:0] cmd;
        logic [AW-1:0] addr;
        logic          tog;
        logic          seen;
        logic          valid;
        logic          err;
    } flt_t;

    flt_t flt_d, flt_q;
    logic frame_tog;

    always_comb begin
        frame_tog   = bits_i[CW - 1 + AW];
        flt_d       = flt_q;
        flt_d.valid = 1'b0;
        flt_d.err   = abort_i;
        if (done_i && (!flt_q.seen || frame_tog != flt_q.tog)) begin
            flt_d.cmd   = {~bits_i[NS-1], bits_i[CW-2:0]};
            flt_d.addr  = bits_i[CW-1 +: AW];
            flt_d.tog   = frame_tog;
            flt_d.seen  = 1'b1;
            flt_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flt_q <= '0;
        else         flt_q <= flt_d;
    end

    assign cmd_o   = flt_q.cmd;
    assign addr_o  = flt_q.addr;
    assign tog_o   = flt_q.tog;
    assign valid_o = flt_q.valid;
    assign err_o   = flt_q.err;
endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder #(
    parameter int CLKS_PER_US = 8,
    parameter int BIT_US      = 1778,
    parameter int ADDR_W      = 5,
    parameter int CMD_W       = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ir_n_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              toggle_o,
    output logic              cmd_valid_o,
    output logic              frame_err_o
);
    // second start bit + toggle + address + low command bits
    localparam int NS = ADDR_W + CMD_W + 1;

    logic          tick, level, edge_seen, done, abort;
    logic [NS-1:0] bits;

    ird_tick #(.DIV(CLKS_PER_US)) u_tick (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    ird_sync #(.IDLE_LEVEL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(ir_n_i),
        .level_o(level),
        .edge_o (edge_seen)
    );

    ird_sampler #(.BIT_TICKS(BIT_US), .NS(NS)) u_sampler (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .level_i(level),
        .edge_i (edge_seen),
        .done_o (done),
        .abort_o(abort),
        .bits_o (bits)
    );

    ird_repeat_filter #(.AW(ADDR_W), .CW(CMD_W), .NS(NS)) u_filter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .done_i (done),
        .abort_i(abort),
        .bits_i (bits),
        .cmd_o  (cmd_o),
        .addr_o (addr_o),
        .tog_o  (toggle_o),
        .valid_o(cmd_valid_o),
        .err_o  (frame_err_o)
    );
endmodule

// File: rtl/ird_checker.sv
module ird_checker #(
    parameter int AW = 5,
    parameter int CW = 7
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          valid_i,
    input logic          err_i,
    input logic [CW-1:0] cmd_i,
    input logic [AW-1:0] addr_i,
    input logic          tog_i
);
    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      seen_q <= 1'b0;
        else if (valid_i) seen_q <= 1'b1;
    end

    // R9
    strobe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_i && err_i));

    // R8
    valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> !valid_i);

    // R6
    err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |=> !err_i);

    // R8
    outputs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> $stable({cmd_i, addr_i, tog_i}));

    // R7
    toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && seen_q) |-> (tog_i != $past(tog_i)));
endmodule

bind ir_frame_decoder ird_checker #(.AW(ADDR_W), .CW(CMD_W)) u_ird_checker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(cmd_valid_o),
    .err_i  (frame_err_o),
    .cmd_i  (cmd_o),
    .addr_i (addr_o),
    .tog_i  (toggle_o)
);

// File: tb/ir_frame_decoder_bench.sv
module ir_frame_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam int BIT        = 64;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic              s2;
        logic              tog;
        logic [4:0]        addr;
        logic [5:0]        cmd;
        logic [7:0]        per;
        logic signed [7:0] step;
        logic [3:0]        nb;
        logic              ev;
        logic              ee;
    } vec_t;

    // frame fields, bit period (us), per-bit period change, bits sent after S1, expected strobes
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 5'h05, 6'h0C, 8'd64,  8'sd0, 4'd13, 1'b1, 1'b0},
        '{1'b1, 1'b0, 5'h09, 6'h01, 8'd64,  8'sd0, 4'd13, 1'b0, 1'b0},
        '{1'b1, 1'b1, 5'h1F, 6'h3F, 8'd64,  8'sd0, 4'd13, 1'b1, 1'b0},
        '{1'b0, 1'b0, 5'h0A, 6'h15, 8'd56,  8'sd0, 4'd13, 1'b1, 1'b0},
        '{1'b1, 1'b1, 5'h11, 6'h2A, 8'd64,  8'sd4, 4'd13, 1'b1, 1'b0},
        '{1'b1, 1'b0, 5'h03, 6'h33, 8'd64, -8'sd2, 4'd13, 1'b1, 1'b0},
        '{1'b1, 1'b1, 5'h16, 6'h0E, 8'd64,  8'sd0, 4'd6,  1'b0, 1'b1},
        '{1'b1, 1'b1, 5'h07, 6'h07, 8'd72,  8'sd0, 4'd13, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_n = 1'b1;
    logic [6:0] cmd;
    logic [4:0] addr;
    logic       tog, valid, err;

    int errors = 0;
    int checks = 0;
    int vcount = 0;
    int ecount = 0;
    int both_count = 0;

    logic [6:0] exp_cmd = '0;
    logic [4:0] exp_addr = '0;
    logic       exp_tog = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ir_frame_decoder #(.CLKS_PER_US(CPU), .BIT_US(BIT)) u_ir_frame_decoder (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ir_n_i     (ir_n),
        .cmd_o      (cmd),
        .addr_o     (addr),
        .toggle_o   (tog),
        .cmd_valid_o(valid),
        .frame_err_o(err)
    );

    always @(negedge clk) begin
        if (valid) vcount++;
        if (err) ecount++;
        if (valid && err) both_count++;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    // Manchester: bit value b drives level b in the first half, ~b in the second.
    task automatic send(input logic [13:0] b, input int per, input int step, input int nb);
        int p = per;
        for (int i = 13; i >= 13 - nb; i--) begin
            ir_n = b[i];
            wait_us(p / 2);
            ir_n = ~b[i];
            wait_us(p / 2);
            p += step;
        end
        wait_us(3 * BIT);
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " R3 R4 cmd"}, int'(cmd), int'(exp_cmd));
        check({tag, " R3 addr"}, int'(addr), int'(exp_addr));
        check({tag, " R3 R7 toggle"}, int'(tog), int'(exp_tog));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int v0, e0;
        logic [13:0] fb;

        // R1: reset state
        repeat (5) @(negedge clk);
        check("R1 valid in reset", int'(valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 err after reset", int'(err), 0);
        check_outputs("R1 reset");

        // Vector walk: R3 R4 R5 R6 R7 R8 R10
        for (int k = 0; k < NVEC; k++) begin
            v0 = vcount;
            e0 = ecount;
            ir_n = 1'b1;
            wait_us(200);
            fb = {1'b1, VECS[k].s2, VECS[k].tog, VECS[k].addr, VECS[k].cmd};
            send(fb, int'(VECS[k].per), int'(VECS[k].step), int'(VECS[k].nb));
            if (VECS[k].ev) begin
                exp_cmd  = {~VECS[k].s2, VECS[k].cmd};
                exp_addr = VECS[k].addr;
                exp_tog  = VECS[k].tog;
            end
            check($sformatf("R5 R7 R8 R10 vec%0d valid strobes", k), vcount - v0, int'(VECS[k].ev));
            check($sformatf("R6 vec%0d error strobes", k), ecount - e0, int'(VECS[k].ee));
            check_outputs($sformatf("R8 vec%0d", k));
        end

        // R2: low line, then only half a period of high before the first mid-bit edge
        v0 = vcount;
        e0 = ecount;
        ir_n = 1'b0;
        wait_us(3 * BIT);
        send({1'b1, 1'b1, 1'b0, 5'h12, 6'h24}, BIT, 0, 13);
        check("R2 short idle valid", vcount - v0, 0);
        check("R2 short idle err", ecount - e0, 0);
        check_outputs("R2 short idle");

        // R2: same frame after a proper idle lead-in is decoded
        v0 = vcount;
        ir_n = 1'b1;
        wait_us(200);
        send({1'b1, 1'b1, 1'b0, 5'h12, 6'h24}, BIT, 0, 13);
        exp_cmd  = 7'h24;
        exp_addr = 5'h12;
        exp_tog  = 1'b0;
        check("R2 rearmed valid", vcount - v0, 1);
        check_outputs("R2 rearmed");

        // R9
        check("R9 coincident strobes", both_count, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule